// File: doc/BRIEF.md
# Load Result Formatter with Condition Test

This block sits at the write-back end of a 64-bit pipeline. It takes a doubleword fetched from memory, or a result from an execution unit, and turns it into the value that goes into the destination register. A crossbar of eight byte-wide 8:1 multiplexers rotates the doubleword so the addressed byte lands in the low byte of the result, and it can mirror the byte order in the same step. Per-byte logic then clears bytes above the access size or fills them with the sign, and it can splice bytes kept from an earlier doubleword into the result. A zero test on the 64-bit result produces a four-bit condition field and its write strobe.

An access that crosses a doubleword boundary arrives as two beats. The first beat carries the doubleword that holds the start address. Its rotated bytes go into a holding register and it produces no result. The second beat carries the next doubleword with the same offset, size and flags. The block merges the held bytes with the new ones and produces the result. Execution results pass through unchanged when presented with offset 0, size code 3 and no flags set. Every accepted beat gives its outputs one clock later.

Top module: `ldfmt_writeback`

## Requirements
- R1: After reset, `out_valid`, `out_cr0_we` and `out_data` are all zero.
- R2: For a beat accepted without reversal, output byte i (bits 8i+7..8i) equals input byte (offset+i) mod 8 for every i below the access size. The size code is 0, 1, 2 or 3, for 1, 2, 4 or 8 bytes. The result appears on the outputs on the clock edge after the beat is accepted.
- R3: With `in_byterev` set, output byte i equals input byte (offset+size-1-i) mod 8 for every i below the access size.
- R4: With `in_sext` clear, output bytes at and above the access size are zero.
- R5: With `in_sext` set and size code 0, 1 or 2, every output byte at and above the access size is 8'hFF when bit 7 of result byte size-1 is one, and 8'h00 otherwise. With size code 3, `in_sext` has no effect.
- R6: A beat with `in_first` set gives `out_valid` and `out_cr0_we` low on the next cycle, and it keeps its rotated bytes for the following second beat.
- R7: On a beat with `in_second` set, each result byte is taken from the memory byte at address offset+i. Addresses 0..7 are bytes of the held first doubleword and addresses 8..15 are bytes 0..7 of the current doubleword.
- R8: A split access with `in_byterev` set takes result byte i from memory address offset+size-1-i, with the same two-doubleword addressing as R7.
- R9: When `out_cr0_we` is high, `out_cr0` is {LT, GT, EQ, SO} in bits 3..0. LT is bit 63 of `out_data`. EQ is set when all 64 bits are zero. GT is set when neither LT nor EQ is set. SO is `in_so` as sampled with the beat.
- R10: `out_cr0_we` is high exactly when a result is produced from a beat that had `in_rc` set.
- R11: A cycle with `in_valid` low gives `out_valid` and `out_cr0_we` low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Beat present this cycle |
| in_data | input | 64 | Incoming doubleword |
| in_offset | input | 3 | Byte offset of the access inside the first doubleword |
| in_size | input | 2 | Access size code: 0=1, 1=2, 2=4, 3=8 bytes |
| in_byterev | input | 1 | Reverse byte order of the access |
| in_sext | input | 1 | Sign-extend from the top byte of the access |
| in_first | input | 1 | First beat of a boundary-crossing access |
| in_second | input | 1 | Second beat of a boundary-crossing access |
| in_rc | input | 1 | Request a condition field update |
| in_so | input | 1 | Summary-overflow bit to copy into the field |
| out_valid | output | 1 | Result valid |
| out_data | output | 64 | Formatted result |
| out_cr0 | output | 4 | Condition field {LT, GT, EQ, SO} |
| out_cr0_we | output | 1 | Condition field write strobe |

## Verification
The bench targets split accesses at every offset where the access crosses into the second doubleword, both with and without reversal. A design that chose held bytes by output position instead of by memory address would get reversed splits wrong while plain splits still came out correct. Sign extension is checked with the sign bit both set and clear, and with the sign byte sitting in the held half of a split. A design that took the sign from the unspliced crossbar byte would then fill the top bytes wrongly. Zero and negative results check the one-hot LT/GT/EQ code. A first beat that raised `out_valid`, or a holding register that changed on a later single beat, shows up as a miscompare on the next cycle.

// File: rtl/ldfmt_pkg.sv
package ldfmt_pkg;

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } cr0_t;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } acc_size_e;

endpackage

// File: rtl/fmt_byte_xbar.sv
module fmt_byte_xbar #(
    parameter int NBYTES = 8,
    localparam int OFFW  = $clog2(NBYTES),
    localparam int DW    = NBYTES * 8,
    localparam int KW    = OFFW + 2
) (
    input  logic [DW-1:0]     data_i,
    input  logic [OFFW-1:0]   offset_i,
    input  logic [OFFW:0]     size_bytes_i,
    input  logic              byterev_i,
    output logic [DW-1:0]     rot_o,
    output logic [NBYTES-1:0] in_first_dw_o
);

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        logic [KW-1:0]   addr_k;
        logic [OFFW-1:0] sel;

        // memory address of the byte that lands in output lane g
        assign addr_k = byterev_i
                      ? KW'(offset_i) + KW'(size_bytes_i) - KW'(1) - KW'(g)
                      : KW'(offset_i) + KW'(g);
        assign sel              = addr_k[OFFW-1:0];
        assign rot_o[g*8 +: 8]  = data_i[sel*8 +: 8];
        assign in_first_dw_o[g] = (addr_k < KW'(NBYTES));
    end

endmodule

// File: rtl/fmt_lane.sv
module fmt_lane (
    input  logic [7:0] spl_byte_i,
    input  logic       keep_i,
    input  logic       ext_en_i,
    input  logic       sign_i,
    output logic [7:0] out_byte_o
);

    always_comb begin
        if (keep_i)
            out_byte_o = spl_byte_i;
        else if (ext_en_i && sign_i)
            out_byte_o = 8'hFF;
        else
            out_byte_o = 8'h00;
    end

endmodule

// File: rtl/fmt_cr0.sv
module fmt_cr0
    import ldfmt_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0] value_i,
    input  logic         so_i,
    output cr0_t         flags_o
);

    always_comb begin
        flags_o.lt = value_i[W-1];
        flags_o.eq = (value_i == '0);
        flags_o.gt = !flags_o.lt && !flags_o.eq;
        flags_o.so = so_i;
    end

endmodule

// File: rtl/ldfmt_writeback.sv
module ldfmt_writeback
    import ldfmt_pkg::*;
#(
    parameter int NBYTES = 8,
    localparam int OFFW  = $clog2(NBYTES),
    localparam int SZW   = $clog2(OFFW + 1),
    localparam int DW    = NBYTES * 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [DW-1:0]   in_data,
    input  logic [OFFW-1:0] in_offset,
    input  logic [SZW-1:0]  in_size,
    input  logic            in_byterev,
    input  logic            in_sext,
    input  logic            in_first,
    input  logic            in_second,
    input  logic            in_rc,
    input  logic            in_so,
    output logic            out_valid,
    output logic [DW-1:0]   out_data,
    output logic [3:0]      out_cr0,
    output logic            out_cr0_we
);

    typedef struct packed {
        logic          valid;
        logic [DW-1:0] data;
        cr0_t          cr0;
        logic          cr0_we;
        logic [DW-1:0] held;
    } wb_state_t;

    wb_state_t st_d, st_q;

    logic [OFFW:0]     size_bytes;
    logic [DW-1:0]     rot_data;
    logic [NBYTES-1:0] from_first;
    logic [DW-1:0]     spl_data;
    logic [DW-1:0]     fmt_data;
    logic              ext_en;
    logic              sign_bit;
    cr0_t              cr0_calc;

    assign size_bytes = (OFFW + 1)'(1) << in_size;
    assign ext_en     = in_sext && (size_bytes < (OFFW + 1)'(NBYTES));

    fmt_byte_xbar #(.NBYTES(NBYTES)) u_xbar (
        .data_i        (in_data),
        .offset_i      (in_offset),
        .size_bytes_i  (size_bytes),
        .byterev_i     (in_byterev),
        .rot_o         (rot_data),
        .in_first_dw_o (from_first)
    );

    // splice held first-doubleword bytes on the second beat
    for (genvar g = 0; g < NBYTES; g++) begin : g_splice
        assign spl_data[g*8 +: 8] = (in_second && from_first[g])
                                  ? st_q.held[g*8 +: 8]
                                  : rot_data[g*8 +: 8];
    end

    // sign comes from the top byte of the access after splicing
    always_comb begin
        sign_bit = 1'b0;
        for (int i = 0; i < NBYTES; i++) begin
            if (i == int'(size_bytes) - 1)
                sign_bit = spl_data[i*8 + 7];
        end
    end

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        fmt_lane u_lane (
            .spl_byte_i (spl_data[g*8 +: 8]),
            .keep_i     ((OFFW + 1)'(g) < size_bytes),
            .ext_en_i   (ext_en),
            .sign_i     (sign_bit),
            .out_byte_o (fmt_data[g*8 +: 8])
        );
    end

    fmt_cr0 #(.W(DW)) u_cr0 (
        .value_i (fmt_data),
        .so_i    (in_so),
        .flags_o (cr0_calc)
    );

    always_comb begin
        st_d        = st_q;
        st_d.valid  = in_valid && !in_first;
        st_d.cr0_we = in_valid && !in_first && in_rc;
        if (in_valid && !in_first) begin
            st_d.data = fmt_data;
            st_d.cr0  = cr0_calc;
        end
        if (in_valid && in_first)
            st_d.held = rot_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign out_valid  = st_q.valid;
    assign out_data   = st_q.data;
    assign out_cr0    = st_q.cr0;
    assign out_cr0_we = st_q.cr0_we;

    AST_FIRST_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_first) |=> (!out_valid && !out_cr0_we)); // R6
    AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_first) |=> $stable(st_q.held)); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_cr0_we)); // R11
    AST_RC_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_first && !in_rc) |=> !out_cr0_we); // R10
    AST_CR0_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        out_cr0_we |-> ($countones(out_cr0[3:1]) == 1)); // R9
    AST_CR0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_cr0_we |-> (out_cr0[1] == (out_data == '0))); // R9
    AST_BYTE_TRIM: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_first && in_size == SZ_BYTE && !in_sext)
        |=> (out_data[DW-1:8] == '0)); // R4

endmodule

// File: tb/tb_ldfmt_writeback.sv
module tb_ldfmt_writeback;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_data = '0;
    logic [2:0]  in_offset = '0;
    logic [1:0]  in_size = '0;
    logic        in_byterev = 1'b0;
    logic        in_sext = 1'b0;
    logic        in_first = 1'b0;
    logic        in_second = 1'b0;
    logic        in_rc = 1'b0;
    logic        in_so = 1'b0;
    logic        out_valid;
    logic [63:0] out_data;
    logic [3:0]  out_cr0;
    logic        out_cr0_we;

    int n_checks = 0;
    int n_fails  = 0;
    logic [63:0] prev_dw = '0;

    always #4 clk = ~clk;

    ldfmt_writeback dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_offset(in_offset), .in_size(in_size), .in_byterev(in_byterev),
        .in_sext(in_sext), .in_first(in_first), .in_second(in_second),
        .in_rc(in_rc), .in_so(in_so), .out_valid(out_valid),
        .out_data(out_data), .out_cr0(out_cr0), .out_cr0_we(out_cr0_we)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // behavioural model: lay the access out in a 16-byte memory image
    function automatic logic [63:0] model(logic [63:0] cur, logic [63:0] prev,
                                          int off, int sz, bit rev, bit sext, bit second);
        logic [7:0] mem [16];
        logic [63:0] r = '0;
        int nb = 1 << sz;
        for (int j = 0; j < 8; j++) begin
            mem[j]     = second ? prev[j*8 +: 8] : cur[j*8 +: 8];
            mem[j + 8] = cur[j*8 +: 8];
        end
        for (int i = 0; i < nb; i++) begin
            int idx = rev ? off + nb - 1 - i : off + i;
            r[i*8 +: 8] = mem[idx];
        end
        if (sext && nb < 8 && r[nb*8 - 1])
            for (int i = nb; i < 8; i++) r[i*8 +: 8] = 8'hFF;
        return r;
    endfunction

    task automatic beat(string tag, bit v, logic [63:0] d, int off, int sz, bit rev,
                        bit sext, bit first, bit second, bit rc, bit so);
        logic [63:0] e;
        logic [3:0]  ec;
        bit ev, ew;
        in_valid = v; in_data = d; in_offset = 3'(off); in_size = 2'(sz);
        in_byterev = rev; in_sext = sext; in_first = first; in_second = second;
        in_rc = rc; in_so = so;
        ev = v && !first;
        ew = ev && rc;
        e  = model(d, prev_dw, off, sz, rev, sext, second);
        ec = {e[63], !e[63] && (e != 0), e == 0, so};
        if (v && first) prev_dw = d;
        @(negedge clk);
        chk({tag, " valid"}, 64'(out_valid), 64'(ev));
        chk({"R10 ", tag, " cr0_we"}, 64'(out_cr0_we), 64'(ew));
        if (ev) chk({tag, " data"}, out_data, e);
        if (ew) chk({"R9 ", tag, " cr0"}, 64'(out_cr0), 64'(ec));
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    initial begin
        #(8 * 150000);
        n_fails++;
        $display("FAIL watchdog act=running exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 valid", 64'(out_valid), 64'd0);
        chk("R1 cr0_we", 64'(out_cr0_we), 64'd0);
        chk("R1 data", out_data, 64'd0);
        rst_n = 1'b1;

        // directed: plain, reversed, trimmed, sign-extended
        beat("R2 dword", 1, 64'h8877665544332211, 0, 3, 0, 0, 0, 0, 1, 0);
        beat("R2 byte off5", 1, 64'h8877665544332211, 5, 0, 0, 0, 0, 0, 1, 1);
        beat("R3 word rev off4", 1, 64'h8877665544332211, 4, 2, 1, 0, 0, 0, 1, 0);
        beat("R4 half trim", 1, 64'hFFFFFFFFFFFF8001, 0, 1, 0, 0, 0, 0, 1, 0);
        beat("R5 half neg", 1, 64'h0000000000008001, 0, 1, 0, 1, 0, 0, 1, 0);
        beat("R5 word pos", 1, 64'hFFFFFFFF7FFFFFFF, 0, 2, 0, 1, 0, 0, 1, 1);
        beat("R5 dword sext ignored", 1, 64'h0123456789ABCDEF, 0, 3, 0, 1, 0, 0, 1, 0);
        beat("R9 zero", 1, 64'h0, 0, 3, 0, 0, 0, 0, 1, 1);
        beat("R11 idle", 0, 64'hDEAD, 0, 3, 0, 0, 0, 0, 1, 0);
        // split access, sign byte in the second doubleword
        beat("R6 first", 1, 64'h80FFEEDDCCBBAA99, 6, 2, 0, 1, 1, 0, 1, 0);
        beat("R7 split", 1, 64'h0011223344556680, 6, 2, 0, 1, 0, 1, 1, 0);
        // reversed split, sign byte held from the first doubleword
        beat("R6 first rev", 1, 64'h8877665544332211, 7, 1, 1, 1, 1, 0, 1, 0);
        beat("R8 split rev", 1, 64'h00000000000000AA, 7, 1, 1, 1, 0, 1, 1, 0);
        // held bytes survive intervening single beats
        beat("R6 first", 1, 64'hF0E0D0C0B0A09080, 3, 3, 0, 0, 1, 0, 0, 0);
        beat("R2 between", 1, 64'h1234, 0, 0, 0, 0, 0, 0, 0, 0);
        beat("R11 gap", 0, 64'h0, 0, 0, 0, 0, 0, 0, 0, 0);
        beat("R7 split late", 1, 64'h0706050403020100, 3, 3, 0, 0, 0, 1, 1, 1);

        for (int n = 0; n < 400; n++) begin
            int sz  = $urandom % 4;
            int nb  = 1 << sz;
            int off = $urandom % (9 - nb);
            bit rev = 1'($urandom);
            beat(rev ? "R3 rnd" : "R2 rnd", 1, rnd64(), off, sz, rev,
                 1'($urandom), 0, 0, 1'($urandom), 1'($urandom));
            if ($urandom % 5 == 0)
                beat("R11 rnd idle", 0, rnd64(), 0, 0, 0, 0, 0, 0, 1, 0);
        end
        for (int n = 0; n < 300; n++) begin
            int sz  = 1 + $urandom % 3;
            int nb  = 1 << sz;
            int off = 9 - nb + $urandom % (nb - 1);
            bit rev = 1'($urandom);
            bit sx  = 1'($urandom);
            beat("R6 rnd first", 1, rnd64(), off, sz, rev, sx, 1, 0, 1, 0);
            beat(rev ? "R8 rnd split" : "R7 rnd split", 1, rnd64(), off, sz, rev,
                 sx, 0, 1, 1'($urandom), 1'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule